// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Signature Readout

This block is the test access port of a device that has no dedicated test-reset pin. It is a four-wire serial controller: TMS walks a sixteen-state controller, TDI feeds the selected shift path, and TDO returns its contents. An asynchronous power-on reset (`por_n`) is the only reset. After it, and after five TCK rising edges with TMS high from any state, the controller is in Test-Logic-Reset with the identification instruction active.

A 4-bit instruction register selects one data register. The choices are the 1-bit bypass register, a 32-bit identification register, a boundary register with two cells per pin, a 16-bit user-signature register and a configuration-readback register. The boundary register observes the pins and the core's output enables. Its update stage can take over the pads during external test, and a high-impedance instruction turns every pad driver off. A security input (`secure`) forces configuration readback to zeros. The user signature stays readable whatever `secure` is.

Controller states, all changing on the TCK rising edge (TMS value in brackets):
- Test-Logic-Reset goes to Run-Test/Idle [0].
- Run-Test/Idle goes to Select-DR [1].
- Select-DR goes to Capture-DR [0] or Select-IR [1].
- Capture-DR goes to Shift-DR [0] or Exit1-DR [1].
- Shift-DR stays [0] or goes to Exit1-DR [1].
- Exit1-DR goes to Pause-DR [0] or Update-DR [1].
- Pause-DR stays [0] or goes to Exit2-DR [1].
- Exit2-DR goes to Shift-DR [0] or Update-DR [1].
- Update-DR goes to Run-Test/Idle [0] or Select-DR [1].
- Select-IR goes to Capture-IR [0] or Test-Logic-Reset [1].
- The IR column (Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR, Update-IR) follows the DR column's pattern.

Top module: `jtag_tap_top`

## Requirements
- R1: While `por_n` is low the controller is held in Test-Logic-Reset, the active instruction is 0010, the boundary update stage is all zeros, `tdo_oe` and `tdo` are 0, and the pads follow `core_out`/`core_oe`.
- R2: Five consecutive TCK rising edges with TMS high bring the controller to Test-Logic-Reset from any state, and that state makes 0010 the active instruction.
- R3: State changes follow the transition list above, including Pause/Exit2 detours, and no data shifts in Capture-DR, Exit or Pause states.
- R4: The instruction register is 4 bits and shifts LSB first. Capture-IR loads 0001. The shifted value becomes active only in Update-IR. The opcodes are: 0000 external test, 0001 sample/preload, 0010 identification, 0011 high-impedance, 0100 user signature, 0101 configuration readback, 1111 bypass. Every other opcode acts as bypass.
- R5: Bypass, unknown opcodes and high-impedance select the 1-bit bypass register, which captures 0, so TDO repeats TDI one shift later.
- R6: Identification selects a 32-bit register that captures the `ID_CODE` parameter, whose bit 0 is 1.
- R7: The boundary register has 2*NPIN cells. Cell 2i captures `pin_in[i]` and cell 2i+1 captures `core_oe[i]`, and cell 0 is nearest TDO. The update stage loads from the shift stage in Update-DR, and only under sample/preload or external test.
- R8: Under external test `pad_out[i]` is update cell 2i and `pad_oe[i]` is update cell 2i+1. Under every instruction other than external test and high-impedance, the pads follow `core_out`/`core_oe`.
- R9: Under high-impedance every bit of `pad_oe` is 0.
- R10: The user-signature instruction selects a 16-bit register that captures `sig_value` whether `secure` is 0 or 1.
- R11: Configuration readback captures `cfg_data` when `secure` is 0 and all zeros when `secure` is 1.
- R12: `tdo` and `tdo_oe` change only on the TCK falling edge. `tdo_oe` is 1 exactly while the controller is in Shift-DR or Shift-IR, and then `tdo` shows bit 0 of the selected register. Otherwise `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| secure | input | 1 | Security bit; blocks configuration readback |
| sig_value | input | SIG_W | User signature value |
| cfg_data | input | CFG_W | Configuration readback value |
| pin_in | input | NPIN | Pin levels seen by the boundary cells |
| core_out | input | NPIN | Functional output data from the core |
| core_oe | input | NPIN | Functional output enables from the core |
| pad_out | output | NPIN | Data to the pad drivers |
| pad_oe | output | NPIN | Enables to the pad drivers |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | Drive enable for the TDO pad |

## Verification
The assertions assume that `por_n` is asserted before the first TCK edge and released while TCK is low. They also assume that `secure`, `sig_value`, `cfg_data`, `pin_in` and `core_oe` do not change in the same cycle as a capture that depends on them. The stimulus drives TMS and TDI one time unit after each falling edge, changes the side inputs only while the controller rests in Run-Test/Idle, and releases reset between edges. An undriven TMS is modelled by the bench holding TMS high during reset, matching the pad pull-up.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_SEL_DR,
        ST_CAP_DR,
        ST_SHIFT_DR,
        ST_EXIT1_DR,
        ST_PAUSE_DR,
        ST_EXIT2_DR,
        ST_UPD_DR,
        ST_SEL_IR,
        ST_CAP_IR,
        ST_SHIFT_IR,
        ST_EXIT1_IR,
        ST_PAUSE_IR,
        ST_EXIT2_IR,
        ST_UPD_IR
    } tap_state_e;

    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0001;
    localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0010;
    localparam logic [IR_W-1:0] OP_HIGHZ   = 4'b0011;
    localparam logic [IR_W-1:0] OP_USERSIG = 4'b0100;
    localparam logic [IR_W-1:0] OP_CFGREAD = 4'b0101;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'b1111;

    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    typedef enum logic [2:0] {
        DR_BYPASS,
        DR_IDCODE,
        DR_BOUNDARY,
        DR_SIGNATURE,
        DR_CONFIG
    } dr_sel_e;

    function automatic dr_sel_e dr_select(input logic [IR_W-1:0] op);
        case (op)
            OP_EXTEST, OP_SAMPLE: return DR_BOUNDARY;
            OP_IDCODE:            return DR_IDCODE;
            OP_USERSIG:           return DR_SIGNATURE;
            OP_CFGREAD:           return DR_CONFIG;
            default:              return DR_BYPASS;
        endcase
    endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic tck,
    input  logic por_n,
    input  logic tms,
    output logic tlr,
    output logic cap_dr,
    output logic sh_dr,
    output logic upd_dr,
    output logic cap_ir,
    output logic sh_ir,
    output logic upd_ir
);

    tap_state_e state;
    tap_state_e state_nxt;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) state <= ST_RESET;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RESET:    state_nxt = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     state_nxt = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_DR:   state_nxt = tms ? ST_SEL_IR   : ST_CAP_DR;
            ST_CAP_DR:   state_nxt = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_SHIFT_DR: state_nxt = tms ? ST_EXIT1_DR : ST_SHIFT_DR;
            ST_EXIT1_DR: state_nxt = tms ? ST_UPD_DR   : ST_PAUSE_DR;
            ST_PAUSE_DR: state_nxt = tms ? ST_EXIT2_DR : ST_PAUSE_DR;
            ST_EXIT2_DR: state_nxt = tms ? ST_UPD_DR   : ST_SHIFT_DR;
            ST_UPD_DR:   state_nxt = tms ? ST_SEL_DR   : ST_IDLE;
            ST_SEL_IR:   state_nxt = tms ? ST_RESET    : ST_CAP_IR;
            ST_CAP_IR:   state_nxt = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_SHIFT_IR: state_nxt = tms ? ST_EXIT1_IR : ST_SHIFT_IR;
            ST_EXIT1_IR: state_nxt = tms ? ST_UPD_IR   : ST_PAUSE_IR;
            ST_PAUSE_IR: state_nxt = tms ? ST_EXIT2_IR : ST_PAUSE_IR;
            ST_EXIT2_IR: state_nxt = tms ? ST_UPD_IR   : ST_SHIFT_IR;
            ST_UPD_IR:   state_nxt = tms ? ST_SEL_DR   : ST_IDLE;
        endcase
    end

    always_comb begin
        tlr    = (state == ST_RESET);
        cap_dr = (state == ST_CAP_DR);
        sh_dr  = (state == ST_SHIFT_DR);
        upd_dr = (state == ST_UPD_DR);
        cap_ir = (state == ST_CAP_IR);
        sh_ir  = (state == ST_SHIFT_IR);
        upd_ir = (state == ST_UPD_IR);
    end

    // consecutive TMS-high edge counter, saturating at five
    logic [2:0] tms_run;
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)              tms_run <= '0;
        else if (!tms)           tms_run <= '0;
        else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
    end

    assert_five_tms_reset_R2: assert property (@(posedge tck) disable iff (!por_n)
        (tms_run == 3'd5) |-> (state == ST_RESET));

    assert_upd_dr_exit_R3: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_UPD_DR) |=> (state == ST_IDLE || state == ST_SEL_DR));

    assert_shift_hold_R3: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_SHIFT_DR && !tms) |=> (state == ST_SHIFT_DR));

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
    import jtag_tap_pkg::*;
(
    input  logic            tck,
    input  logic            por_n,
    input  logic            tdi,
    input  logic            tlr,
    input  logic            cap,
    input  logic            sh,
    input  logic            upd,
    output logic [IR_W-1:0] ir,
    output logic            so
);

    logic [IR_W-1:0] sr;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)   sr <= '0;
        else if (cap) sr <= IR_CAPTURE;
        else if (sh)  sr <= {tdi, sr[IR_W-1:1]};
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)   ir <= OP_IDCODE;
        else if (tlr) ir <= OP_IDCODE;
        else if (upd) ir <= sr;
    end

    assign so = sr[0];

    assert_ir_load_R4: assert property (@(posedge tck) disable iff (!por_n)
        upd |=> (ir == $past(sr)));

    assert_reset_idcode_R1: assert property (@(posedge tck) disable iff (!por_n)
        tlr |=> (ir == OP_IDCODE));

endmodule

// File: rtl/jtag_tap_bsr.sv
module jtag_tap_bsr #(
    parameter int NPIN = 4
) (
    input  logic              tck,
    input  logic              por_n,
    input  logic              tdi,
    input  logic              cap,
    input  logic              sh,
    input  logic              upd,
    input  logic [NPIN-1:0]   pin_in,
    input  logic [NPIN-1:0]   core_oe,
    output logic [2*NPIN-1:0] upd_q,
    output logic              so
);

    localparam int CELLS = 2 * NPIN;

    logic [CELLS-1:0] cap_v;
    logic [CELLS-1:0] sr;

    for (genvar i = 0; i < NPIN; i++) begin : g_cell
        assign cap_v[2*i]   = pin_in[i];
        assign cap_v[2*i+1] = core_oe[i];
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)   sr <= '0;
        else if (cap) sr <= cap_v;
        else if (sh)  sr <= {tdi, sr[CELLS-1:1]};
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)   upd_q <= '0;
        else if (upd) upd_q <= sr;
    end

    assign so = sr[0];

    assert_update_hold_R7: assert property (@(posedge tck) disable iff (!por_n)
        !upd |=> $stable(upd_q));

endmodule

// File: rtl/jtag_tap_top.sv
module jtag_tap_top
    import jtag_tap_pkg::*;
#(
    parameter int          NPIN    = 4,
    parameter int          SIG_W   = 16,
    parameter int          CFG_W   = 24,
    parameter logic [31:0] ID_CODE = 32'h0A53_C03F
) (
    input  logic             tck,
    input  logic             por_n,
    input  logic             tms,
    input  logic             tdi,
    input  logic             secure,
    input  logic [SIG_W-1:0] sig_value,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic [NPIN-1:0]  pin_in,
    input  logic [NPIN-1:0]  core_out,
    input  logic [NPIN-1:0]  core_oe,
    output logic [NPIN-1:0]  pad_out,
    output logic [NPIN-1:0]  pad_oe,
    output logic             tdo,
    output logic             tdo_oe
);

    localparam int CELLS = 2 * NPIN;
    localparam int ID_W  = 32;

    logic tlr, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir;
    logic [IR_W-1:0] ir;
    logic            ir_so;
    dr_sel_e         sel;

    jtag_tap_fsm u_fsm (
        .tck    (tck),
        .por_n  (por_n),
        .tms    (tms),
        .tlr    (tlr),
        .cap_dr (cap_dr),
        .sh_dr  (sh_dr),
        .upd_dr (upd_dr),
        .cap_ir (cap_ir),
        .sh_ir  (sh_ir),
        .upd_ir (upd_ir)
    );

    jtag_tap_ir u_ir (
        .tck   (tck),
        .por_n (por_n),
        .tdi   (tdi),
        .tlr   (tlr),
        .cap   (cap_ir),
        .sh    (sh_ir),
        .upd   (upd_ir),
        .ir    (ir),
        .so    (ir_so)
    );

    assign sel = dr_select(ir);

    logic             bsr_sel;
    logic [CELLS-1:0] bsr_upd_q;
    logic             bsr_so;

    assign bsr_sel = (sel == DR_BOUNDARY);

    jtag_tap_bsr #(.NPIN(NPIN)) u_bsr (
        .tck     (tck),
        .por_n   (por_n),
        .tdi     (tdi),
        .cap     (cap_dr & bsr_sel),
        .sh      (sh_dr & bsr_sel),
        .upd     (upd_dr & bsr_sel),
        .pin_in  (pin_in),
        .core_oe (core_oe),
        .upd_q   (bsr_upd_q),
        .so      (bsr_so)
    );

    // small data registers
    logic             byp_sr;
    logic [ID_W-1:0]  id_sr;
    logic [SIG_W-1:0] sig_sr;
    logic [CFG_W-1:0] cfg_sr;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            byp_sr <= 1'b0;
            id_sr  <= '0;
            sig_sr <= '0;
            cfg_sr <= '0;
        end else if (cap_dr) begin
            case (sel)
                DR_BYPASS:    byp_sr <= 1'b0;
                DR_IDCODE:    id_sr  <= ID_CODE;
                DR_SIGNATURE: sig_sr <= sig_value;
                DR_CONFIG:    cfg_sr <= secure ? '0 : cfg_data;
                default:      ;
            endcase
        end else if (sh_dr) begin
            case (sel)
                DR_BYPASS:    byp_sr <= tdi;
                DR_IDCODE:    id_sr  <= {tdi, id_sr[ID_W-1:1]};
                DR_SIGNATURE: sig_sr <= {tdi, sig_sr[SIG_W-1:1]};
                DR_CONFIG:    cfg_sr <= {tdi, cfg_sr[CFG_W-1:1]};
                default:      ;
            endcase
        end
    end

    logic dr_so;
    always_comb begin
        case (sel)
            DR_IDCODE:    dr_so = id_sr[0];
            DR_BOUNDARY:  dr_so = bsr_so;
            DR_SIGNATURE: dr_so = sig_sr[0];
            DR_CONFIG:    dr_so = cfg_sr[0];
            default:      dr_so = byp_sr;
        endcase
    end

    // serial output, launched on the falling edge
    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= sh_ir ? ir_so : (sh_dr ? dr_so : 1'b0);
            tdo_oe <= sh_ir | sh_dr;
        end
    end

    // pad control
    always_comb begin
        pad_out = core_out;
        pad_oe  = core_oe;
        if (ir == OP_EXTEST) begin
            for (int i = 0; i < NPIN; i++) begin
                pad_out[i] = bsr_upd_q[2*i];
                pad_oe[i]  = bsr_upd_q[2*i+1];
            end
        end else if (ir == OP_HIGHZ) begin
            pad_oe = '0;
        end
    end

    assert_tdo_window_R12: assert property (@(posedge tck) disable iff (!por_n)
        ((sh_dr | sh_ir) == tdo_oe));

    assert_secure_cfg_zero_R11: assert property (@(posedge tck) disable iff (!por_n)
        (cap_dr && sel == DR_CONFIG && secure) |=> (cfg_sr == '0));

endmodule

// File: tb/jtag_tap_top_tb.sv
module jtag_tap_top_tb;

    localparam int TCK_PERIOD = 20;
    localparam int NPIN  = 4;
    localparam int SIG_W = 16;
    localparam int CFG_W = 24;
    localparam int CELLS = 2 * NPIN;
    localparam logic [31:0] ID = 32'h0A53_C03F;

    // behavioural controller states
    localparam int S_TLR = 0,  S_RTI = 1,  S_SDR = 2,  S_CDR = 3;
    localparam int S_SHDR = 4, S_E1DR = 5, S_PDR = 6,  S_E2DR = 7;
    localparam int S_UDR = 8,  S_SIR = 9,  S_CIR = 10, S_SHIR = 11;
    localparam int S_E1IR = 12, S_PIR = 13, S_E2IR = 14, S_UIR = 15;

    logic tck = 1'b0;
    logic por_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic secure = 1'b0;
    logic [SIG_W-1:0] sig_value = 16'hC0DE;
    logic [CFG_W-1:0] cfg_data = 24'h5A3C96;
    logic [NPIN-1:0] pin_in = 4'b1010;
    logic [NPIN-1:0] core_out = 4'b0110;
    logic [NPIN-1:0] core_oe = 4'b0011;
    logic [NPIN-1:0] pad_out, pad_oe;
    logic tdo, tdo_oe;

    jtag_tap_top #(.NPIN(NPIN), .SIG_W(SIG_W), .CFG_W(CFG_W), .ID_CODE(ID)) u_dut (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .secure(secure),
        .sig_value(sig_value), .cfg_data(cfg_data), .pin_in(pin_in),
        .core_out(core_out), .core_oe(core_oe), .pad_out(pad_out),
        .pad_oe(pad_oe), .tdo(tdo), .tdo_oe(tdo_oe)
    );

    always #(TCK_PERIOD/2) tck = ~tck;

    int vectors = 0;
    int miscompares = 0;

    // reference model state
    int          m_state = S_TLR;
    logic [3:0]  m_ir = 4'b0010;
    logic [3:0]  m_irsh = 4'b0000;
    logic [63:0] m_dr = '0;
    int          m_len = 1;
    logic [CELLS-1:0] m_upd = '0;
    logic        m_tdo = 1'b0;
    logic        m_oe = 1'b0;

    task automatic check(input string r, input string what, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
        end
    endtask

    function automatic int next_state(input int s, input bit m);
        case (s)
            S_TLR:  return m ? S_TLR  : S_RTI;
            S_RTI:  return m ? S_SDR  : S_RTI;
            S_SDR:  return m ? S_SIR  : S_CDR;
            S_CDR:  return m ? S_E1DR : S_SHDR;
            S_SHDR: return m ? S_E1DR : S_SHDR;
            S_E1DR: return m ? S_UDR  : S_PDR;
            S_PDR:  return m ? S_E2DR : S_PDR;
            S_E2DR: return m ? S_UDR  : S_SHDR;
            S_UDR:  return m ? S_SDR  : S_RTI;
            S_SIR:  return m ? S_TLR  : S_CIR;
            S_CIR:  return m ? S_E1IR : S_SHIR;
            S_SHIR: return m ? S_E1IR : S_SHIR;
            S_E1IR: return m ? S_UIR  : S_PIR;
            S_PIR:  return m ? S_E2IR : S_PIR;
            S_E2IR: return m ? S_UIR  : S_SHIR;
            default: return m ? S_SDR : S_RTI;
        endcase
    endfunction

    task automatic model_capture();
        m_dr = '0;
        case (m_ir)
            4'b0000, 4'b0001: begin
                for (int i = 0; i < NPIN; i++) begin
                    m_dr[2*i]   = pin_in[i];
                    m_dr[2*i+1] = core_oe[i];
                end
                m_len = CELLS;
            end
            4'b0010: begin m_dr[31:0] = ID; m_len = 32; end
            4'b0100: begin m_dr[SIG_W-1:0] = sig_value; m_len = SIG_W; end
            4'b0101: begin m_dr[CFG_W-1:0] = secure ? '0 : cfg_data; m_len = CFG_W; end
            default: m_len = 1;
        endcase
    endtask

    task automatic model_pos(input bit m, input bit d);
        case (m_state)
            S_TLR:  m_ir = 4'b0010;
            S_CIR:  m_irsh = 4'b0001;
            S_SHIR: m_irsh = {d, m_irsh[3:1]};
            S_UIR:  m_ir = m_irsh;
            S_CDR:  model_capture();
            S_SHDR: begin m_dr = m_dr >> 1; m_dr[m_len-1] = d; end
            S_UDR:  if (m_ir == 4'b0000 || m_ir == 4'b0001) m_upd = m_dr[CELLS-1:0];
            default: ;
        endcase
        m_state = next_state(m_state, m);
    endtask

    task automatic model_neg();
        m_oe = (m_state == S_SHDR) || (m_state == S_SHIR);
        if (m_state == S_SHIR)      m_tdo = m_irsh[0];
        else if (m_state == S_SHDR) m_tdo = m_dr[0];
        else                        m_tdo = 1'b0;
    endtask

    task automatic compare_all();
        logic [NPIN-1:0] e_out, e_oe;
        string pr;
        e_out = core_out;
        e_oe  = core_oe;
        pr = "R8";
        if (m_ir == 4'b0000) begin
            for (int i = 0; i < NPIN; i++) begin
                e_out[i] = m_upd[2*i];
                e_oe[i]  = m_upd[2*i+1];
            end
        end else if (m_ir == 4'b0011) begin
            e_oe = '0;
            pr = "R9";
        end
        check("R12", "tdo_oe", 64'(tdo_oe), 64'(m_oe));
        check("R12", "tdo", 64'(tdo), 64'(m_tdo));
        check(pr, "pad_out", 64'(pad_out), 64'(e_out));
        check(pr, "pad_oe", 64'(pad_oe), 64'(e_oe));
    endtask

    task automatic tick(input bit m, input bit d);
        tms = m;
        tdi = d;
        @(posedge tck);
        model_pos(m, d);
        @(negedge tck);
        #1;
        model_neg();
        compare_all();
    endtask

    // from Run-Test/Idle, load an instruction; returns the captured IR bits
    task automatic load_ir(input logic [3:0] op, output logic [3:0] cap);
        tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
        for (int k = 0; k < 4; k++) begin
            cap[k] = tdo;
            tick(k == 3, op[k]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    // from Run-Test/Idle, capture, shift len bits and update
    task automatic shift_dr(input int len, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int k = 0; k < len; k++) begin
            dout[k] = tdo;
            tick(k == len - 1, din[k]);
        end
        tick(1, 0); tick(0, 0);
    endtask

    initial begin
        repeat (50000) @(posedge tck);
        miscompares++;
        $display("FAIL R12 watchdog expired actual=%0d expected=%0d", vectors, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [3:0]  irc;
        logic [63:0] rd;
        logic [63:0] exp_bsr;

        // R1: reset state
        repeat (3) @(negedge tck);
        #1;
        check("R1", "tdo_oe", 64'(tdo_oe), 64'd0);
        check("R1", "tdo", 64'(tdo), 64'd0);
        check("R1", "pad_out", 64'(pad_out), 64'(core_out));
        check("R1", "pad_oe", 64'(pad_oe), 64'(core_oe));
        por_n = 1'b1;
        tick(0, 0);

        // R6: identification after reset (R1: default instruction)
        shift_dr(32, 64'h0, rd);
        check("R6", "idcode", rd, 64'(ID));

        // R3: pause/exit2 detour, capture then no shift until Shift-DR
        tick(1, 0); tick(0, 0); tick(1, 0); tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 0);
        rd = '0;
        for (int k = 0; k < 32; k++) begin
            rd[k] = tdo;
            tick(k == 31, 1'b0);
        end
        tick(1, 0); tick(0, 0);
        check("R3", "idcode_pause", rd, 64'(ID));

        // R2: five TMS-high edges from Shift-DR return to reset
        load_ir(4'b1111, irc);
        check("R4", "ir_capture", 64'(irc), 64'h1);
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int k = 0; k < 5; k++) tick(1, 0);
        check("R2", "tdo_oe_in_reset", 64'(tdo_oe), 64'd0);
        tick(0, 0);
        shift_dr(32, 64'h0, rd);
        check("R2", "idcode_after_tms_reset", rd, 64'(ID));

        // R7: sample/preload capture and preload
        load_ir(4'b0001, irc);
        exp_bsr = '0;
        for (int i = 0; i < NPIN; i++) begin
            exp_bsr[2*i]   = pin_in[i];
            exp_bsr[2*i+1] = core_oe[i];
        end
        shift_dr(CELLS, 64'hC5, rd);
        check("R7", "bsr_capture", rd, exp_bsr);
        check("R8", "sample_pad_out", 64'(pad_out), 64'(core_out));

        // R8: external test drives preloaded values
        load_ir(4'b0000, irc);
        check("R8", "extest_pad_out", 64'(pad_out), 64'h0B);
        check("R8", "extest_pad_oe", 64'(pad_oe), 64'h08);
        shift_dr(CELLS, 64'h3A, rd);
        check("R8", "extest_pad_out2", 64'(pad_out), 64'h04);
        check("R8", "extest_pad_oe2", 64'(pad_oe), 64'h07);

        // R7: update stage untouched under bypass
        load_ir(4'b1111, irc);
        shift_dr(4, 64'hF, rd);
        load_ir(4'b0000, irc);
        check("R7", "hold_pad_out", 64'(pad_out), 64'h04);
        check("R7", "hold_pad_oe", 64'(pad_oe), 64'h07);

        // R9 / R5: high impedance
        load_ir(4'b0011, irc);
        check("R9", "highz_pad_oe", 64'(pad_oe), 64'h0);
        shift_dr(4, 64'hB, rd);
        check("R5", "highz_bypass", rd, 64'h6);

        // R10: user signature regardless of security
        secure = 1'b0;
        load_ir(4'b0100, irc);
        shift_dr(SIG_W, 64'h0, rd);
        check("R10", "sig_open", rd, 64'(sig_value));
        secure = 1'b1;
        sig_value = 16'h1F2E;
        shift_dr(SIG_W, 64'h0, rd);
        check("R10", "sig_secure", rd, 64'h1F2E);

        // R11: configuration readback
        load_ir(4'b0101, irc);
        shift_dr(CFG_W, 64'h0, rd);
        check("R11", "cfg_secure", rd, 64'h0);
        secure = 1'b0;
        shift_dr(CFG_W, 64'h0, rd);
        check("R11", "cfg_open", rd, 64'(cfg_data));

        // R4 / R5: unknown opcode and all-ones act as bypass
        load_ir(4'b0110, irc);
        shift_dr(3, 64'h5, rd);
        check("R4", "unknown_bypass", rd, 64'h2);
        load_ir(4'b1111, irc);
        shift_dr(2, 64'h3, rd);
        check("R5", "bypass", rd, 64'h2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule